// File: doc/BRIEF.md
# Real-Time Counter with Periodic Event Timer

This block keeps a free-running binary count of timebase ticks. It also raises events from that count. The timebase is one of four tick-enable inputs. The count advances only on the system clock, so each source is a one-cycle enable pulse rather than a clock of its own. The chosen tick can pass through a divide-by-32 stage, a divide-by-512 stage, or both in series. The prescaled tick drives two things: the main counter and a short periodic counter.

Three sticky flags sit in a status word:
- a compare flag, set when a 12-bit window of the count equals a programmed value;
- a rollover flag, set when the count wraps to zero;
- a periodic flag, set every N prescaled ticks.

Each flag is cleared by writing a one to its bit. The interrupt outputs and the wakeup output come from these flags and their enables.

One 32-bit control word configures everything. Only the power-on reset clears the control word. The ordinary system reset clears the count and the flags. When the master enable is cleared, all counting state is held at zero, so the source and dividers can be changed cleanly.

Top module: `rtc_api_timer`

## Requirements
- R1: A write to address 0 stores the control word, and a read of address 0 returns it. Bit positions, numbered from the LSB:
  - [31] enable
  - [30] compare interrupt enable
  - [29] freeze enable
  - [28] rollover enable
  - [27:16] compare value
  - [15] periodic enable
  - [14] periodic interrupt enable
  - [13:12] source select
  - [11] divide-512
  - [10] divide-32
  - [9:0] periodic length
- R2: The control word resets to zero only while `por_n` is low. A pulse on `rst_n` leaves it unchanged and clears the count and the flags.
- R3: While enable is 0, the count, the prescaler, the periodic counter and all three flags are held at zero.
- R4: Each prescaled tick taken from `src_tick[select]` advances the count by one. A read of address 2 returns the count, zero-extended.
- R5: With divide-32 set, one prescaled tick passes for every 32 source ticks. With divide-512 set, one passes for every 512. With both set, one passes for every 16384.
- R6: The compare flag (status bit 0) is set once, in the cycle after the count enters a state whose bits [CMP_LSB+11:CMP_LSB] equal the compare value. It does not set again while that match persists. A compare value of zero never sets it.
- R7: When the count wraps from all ones to zero and rollover enable is 1, the rollover flag (status bit 2) is set. With rollover enable 0, it stays clear. `wakeup` follows the rollover flag.
- R8: `rtc_irq` is 1 when compare interrupt enable is 1 and either the compare flag or the rollover flag is set. `api_irq` is 1 when periodic interrupt enable is 1 and the periodic flag is set.
- R9: When freeze enable is 1 and `dbg_mode` is 1, the count holds. It resumes from the held value when `dbg_mode` returns to 0. With freeze enable 0, `dbg_mode` has no effect.
- R10: With periodic enable set and a non-zero length N, the periodic flag (status bit 1) is set on every Nth prescaled tick. A length of zero never sets it.
- R11: A write to address 1 clears each flag whose data bit is 1 and leaves the flags written with 0 unchanged. A flag being set in the same cycle as its clear stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | System reset, active low, clears count and flags |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 status, 2 count |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| src_tick | input | 4 | Timebase tick enables, one per source |
| dbg_mode | input | 1 | Debug-mode indicator |
| rtc_irq | output | 1 | Compare or rollover interrupt request |
| api_irq | output | 1 | Periodic interrupt request |
| wakeup | output | 1 | Rollover wakeup request |

## Verification
The periodic event can set its flag in the same cycle that software writes a one to clear it. The bench sets the periodic length to 1, so that every prescaled tick is an event. It then drives a source tick and the status clear on the same clock edge. Afterwards the periodic flag must still read 1, and a separate clear write with no tick must then bring it to 0.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int CTRL_W = 32;
    localparam int CMP_W  = 12;
    localparam int API_W  = 10;
    localparam int SEL_W  = 2;
    localparam int NSRC   = 1 << SEL_W;

    // register addresses
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_CNT  = 2'd2;

    // status bit positions
    localparam int STAT_CMP = 0;
    localparam int STAT_PER = 1;
    localparam int STAT_ROV = 2;

    // control word, first member is the MSB
    typedef struct packed {
        logic               run;
        logic               cmp_ie;
        logic               frz;
        logic               rov_en;
        logic [CMP_W-1:0]   cmp_val;
        logic               per_en;
        logic               per_ie;
        logic [SEL_W-1:0]   src_sel;
        logic               div512;
        logic               div32;
        logic [API_W-1:0]   per_len;
    } ctrl_t;

    typedef struct packed {
        logic cmp_f;
        logic per_f;
        logic rov_f;
    } flags_t;

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int STAGE_A_W = 5,
    parameter int STAGE_B_W = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick_i,
    input  logic div_a_en,
    input  logic div_b_en,
    output logic tick_o
);

    localparam logic [STAGE_A_W-1:0] A_LAST = '1;
    localparam logic [STAGE_B_W-1:0] B_LAST = '1;

    typedef struct packed {
        logic [STAGE_A_W-1:0] a;
        logic [STAGE_B_W-1:0] b;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       mid_tick;

    always_comb begin
        st_d = st_q;
        // first stage
        if (div_a_en) begin
            mid_tick = tick_i && (st_q.a == A_LAST);
            if (tick_i) st_d.a = st_q.a + 1'b1;
        end else begin
            mid_tick = tick_i;
        end
        // second stage, fed by the first
        if (div_b_en) begin
            tick_o = mid_tick && (st_q.b == B_LAST);
            if (mid_tick) st_d.b = st_q.b + 1'b1;
        end else begin
            tick_o = mid_tick;
        end
        if (clear) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/rtc_main_counter.sv
module rtc_main_counter #(
    parameter int CNT_W   = 32,
    parameter int CMP_LSB = 10,
    parameter int CMP_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick_i,
    input  logic [CMP_W-1:0] cmp_val,
    input  logic             rov_en,
    output logic [CNT_W-1:0] count_o,
    output logic             match_rise_o,
    output logic             rollover_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             match;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       match_now;

    always_comb begin
        st_d         = st_q;
        match_now    = (cmp_val != '0) && (st_q.cnt[CMP_LSB +: CMP_W] == cmp_val);
        match_rise_o = match_now && !st_q.match && !clear;
        rollover_o   = tick_i && rov_en && (st_q.cnt == CNT_TOP) && !clear;
        st_d.match   = match_now;
        if (tick_i) st_d.cnt = st_q.cnt + 1'b1;
        if (clear)  st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;

endmodule

// File: rtl/rtc_period_unit.sv
module rtc_period_unit #(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick_i,
    input  logic             en,
    input  logic [LEN_W-1:0] len,
    output logic             event_o
);

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
    } per_state_t;

    per_state_t st_d, st_q;
    logic [LEN_W-1:0] last_val;

    always_comb begin
        st_d     = st_q;
        last_val = len - 1'b1;
        event_o  = en && tick_i && (len != '0) && (st_q.cnt == last_val) && !clear;
        if (tick_i) begin
            if (event_o) st_d.cnt = '0;
            else         st_d.cnt = st_q.cnt + 1'b1;
        end
        if (clear || !en) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/rtc_api_timer.sv
module rtc_api_timer
    import rtc_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int CMP_LSB = 10
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data,
    input  logic [NSRC-1:0]  src_tick,
    input  logic             dbg_mode,
    output logic             rtc_irq,
    output logic             api_irq,
    output logic             wakeup
);

    localparam int PRE_A_W = 5;   // divide by 32
    localparam int PRE_B_W = 9;   // divide by 512

    ctrl_t      ctrl_d, ctrl_q;
    flags_t     flg_d, flg_q;
    logic       sys_rst_n;
    logic       clear;
    logic       raw_tick;
    logic       pre_tick;
    logic [CNT_W-1:0] count;
    logic       match_rise;
    logic       rollover;
    logic       per_event;
    logic       clr_wr;
    logic       cmp_flag, per_flag, rov_flag;

    assign sys_rst_n = por_n & rst_n;
    assign clear     = !ctrl_q.run;
    // freeze gates the timebase ahead of the whole tick chain
    assign raw_tick  = src_tick[ctrl_q.src_sel] && !(ctrl_q.frz && dbg_mode) && ctrl_q.run;

    rtc_prescaler #(
        .STAGE_A_W (PRE_A_W),
        .STAGE_B_W (PRE_B_W)
    ) u_pre (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .clear    (clear),
        .tick_i   (raw_tick),
        .div_a_en (ctrl_q.div32),
        .div_b_en (ctrl_q.div512),
        .tick_o   (pre_tick)
    );

    rtc_main_counter #(
        .CNT_W   (CNT_W),
        .CMP_LSB (CMP_LSB),
        .CMP_W   (CMP_W)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (sys_rst_n),
        .clear        (clear),
        .tick_i       (pre_tick),
        .cmp_val      (ctrl_q.cmp_val),
        .rov_en       (ctrl_q.rov_en),
        .count_o      (count),
        .match_rise_o (match_rise),
        .rollover_o   (rollover)
    );

    rtc_period_unit #(
        .LEN_W (API_W)
    ) u_per (
        .clk     (clk),
        .rst_n   (sys_rst_n),
        .clear   (clear),
        .tick_i  (pre_tick),
        .en      (ctrl_q.per_en),
        .len     (ctrl_q.per_len),
        .event_o (per_event)
    );

    // next-state of control and flags
    always_comb begin
        ctrl_d = ctrl_q;
        flg_d  = flg_q;
        clr_wr = wr_en && (addr == ADDR_STAT);
        if (wr_en && (addr == ADDR_CTRL)) ctrl_d = ctrl_t'(wr_data);
        // write-one-to-clear, a set in the same cycle wins
        if (clr_wr) begin
            if (wr_data[STAT_CMP]) flg_d.cmp_f = 1'b0;
            if (wr_data[STAT_PER]) flg_d.per_f = 1'b0;
            if (wr_data[STAT_ROV]) flg_d.rov_f = 1'b0;
        end
        if (match_rise) flg_d.cmp_f = 1'b1;
        if (per_event)  flg_d.per_f = 1'b1;
        if (rollover)   flg_d.rov_f = 1'b1;
        if (clear)      flg_d = '0;
    end

    // control word: power-on reset only
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    // flags: power-on or system reset
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) flg_q <= '0;
        else            flg_q <= flg_d;
    end

    assign cmp_flag = flg_q.cmp_f;
    assign per_flag = flg_q.per_f;
    assign rov_flag = flg_q.rov_f;

    always_comb begin
        rd_data = '0;
        case (addr)
            ADDR_CTRL: rd_data = ctrl_q;
            ADDR_STAT: begin
                rd_data[STAT_CMP] = cmp_flag;
                rd_data[STAT_PER] = per_flag;
                rd_data[STAT_ROV] = rov_flag;
            end
            ADDR_CNT:  rd_data = 32'(count);
            default:   rd_data = '0;
        endcase
    end

    assign rtc_irq = ctrl_q.cmp_ie && (cmp_flag || rov_flag);
    assign api_irq = ctrl_q.per_ie && per_flag;
    assign wakeup  = rov_flag;

endmodule

// File: rtl/rtc_api_timer_chk.sv
module rtc_api_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             por_n,
    input logic             rst_n,
    input logic             run,
    input logic             frz,
    input logic             rov_en,
    input logic [11:0]      cmp_val,
    input logic             dbg_mode,
    input logic [CNT_W-1:0] count,
    input logic             pre_tick,
    input logic             cmp_flag,
    input logic             per_flag,
    input logic             rov_flag,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic             wr_per_bit
);

    // R3: disabled state forces the count to zero
    a_r3_disabled_zero: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !run |=> (count == '0));

    // R4: no prescaled tick, no change
    a_r4_hold: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (run && !pre_tick) |=> (count == $past(count)));

    // R4: one prescaled tick, one step
    a_r4_step: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (run && pre_tick) |=> (count == CNT_W'($past(count) + 1'b1)));

    // R9: frozen in debug
    a_r9_freeze: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (run && frz && dbg_mode) |=> (count == $past(count)));

    // R6: zero compare value never sets the compare flag
    a_r6_zero_cmp: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $rose(cmp_flag) |-> ($past(cmp_val) != 12'd0));

    // R7: rollover flag needs its enable
    a_r7_rov_gate: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $rose(rov_flag) |-> $past(rov_en));

    // R11: periodic flag falls only by a clear write or disable
    a_r11_per_clear: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $fell(per_flag) |-> $past(!run || (wr_en && addr == 2'd1 && wr_per_bit)));

endmodule

bind rtc_api_timer rtc_api_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .rst_n      (rst_n),
    .run        (ctrl_q.run),
    .frz        (ctrl_q.frz),
    .rov_en     (ctrl_q.rov_en),
    .cmp_val    (ctrl_q.cmp_val),
    .dbg_mode   (dbg_mode),
    .count      (count),
    .pre_tick   (pre_tick),
    .cmp_flag   (cmp_flag),
    .per_flag   (per_flag),
    .rov_flag   (rov_flag),
    .wr_en      (wr_en),
    .addr       (addr),
    .wr_per_bit (wr_data[1])
);

// File: tb/rtc_api_timer_test.sv
module rtc_api_timer_test;

    localparam int CLK_PERIOD = 10;
    localparam int TB_CNT_W   = 14;
    localparam int TB_CMP_LSB = 2;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  src_tick = '0;
    logic        dbg_mode = 1'b0;
    logic        rtc_irq, api_irq, wakeup;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_api_timer #(.CNT_W(TB_CNT_W), .CMP_LSB(TB_CMP_LSB)) uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .src_tick(src_tick),
        .dbg_mode(dbg_mode), .rtc_irq(rtc_irq), .api_irq(api_irq), .wakeup(wakeup)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [1:0]  line;
        logic        d32;
        logic        d512;
        logic [31:0] n;
        logic [31:0] exp_cnt;
    } vec_t;

    // R4 / R5: source select and prescaler vectors
    localparam vec_t VECS [6] = '{
        '{2'd0, 2'd0, 1'b0, 1'b0, 32'd10,    32'd10},
        '{2'd2, 2'd2, 1'b0, 1'b0, 32'd5,     32'd5},
        '{2'd1, 2'd3, 1'b0, 1'b0, 32'd8,     32'd0},
        '{2'd3, 2'd3, 1'b1, 1'b0, 32'd100,   32'd3},
        '{2'd0, 2'd0, 1'b0, 1'b1, 32'd1100,  32'd2},
        '{2'd1, 2'd1, 1'b1, 1'b1, 32'd16387, 32'd1}
    };

    function automatic logic [31:0] mk(input logic run, input logic cie, input logic frz,
                                       input logic rov, input logic [11:0] cmp,
                                       input logic pen, input logic pie, input logic [1:0] sel,
                                       input logic d512, input logic d32, input logic [9:0] plen);
        return {run, cie, frz, rov, cmp, pen, pie, sel, d512, d32, plen};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic ticks(input logic [3:0] mask, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            src_tick = mask;
        end
        @(negedge clk);
        src_tick = '0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;

        // reset state
        rd(2'd0, v); check("R2 ctrl after power-on", v, 32'h0);
        rd(2'd1, v); check("R2 status after power-on", v, 32'h0);
        rd(2'd2, v); check("R2 count after power-on", v, 32'h0);
        check("R8 irqs after power-on", {29'd0, rtc_irq, api_irq, wakeup}, 32'h0);

        // R1 readback
        wr(2'd0, 32'h25A5_3C3C); rd(2'd0, v); check("R1 readback", v, 32'h25A5_3C3C);
        wr(2'd0, 32'h0);

        // R4 / R5 table
        foreach (VECS[k]) begin
            wr(2'd0, 32'h0);
            wr(2'd0, mk(1, 0, 0, 0, 12'd0, 0, 0, VECS[k].sel, VECS[k].d512, VECS[k].d32, 10'd0));
            ticks(4'b0001 << VECS[k].line, int'(VECS[k].n));
            rd(2'd2, v);
            check($sformatf("R4/R5 vector %0d", k), v, VECS[k].exp_cnt);
        end

        // R3: disable clears and holds
        wr(2'd0, 32'h0); rd(2'd2, v); check("R3 count cleared", v, 32'h0);
        ticks(4'b1111, 5); rd(2'd2, v); check("R3 no count while disabled", v, 32'h0);

        // R6: compare window bits [13:2] == 3 -> count 12..15
        wr(2'd0, mk(1, 1, 0, 0, 12'd3, 0, 0, 2'd0, 0, 0, 10'd0));
        ticks(4'b0001, 11); rd(2'd1, v); check("R6 no flag before match", v, 32'h0);
        ticks(4'b0001, 1);  rd(2'd1, v); check("R6 flag on match", v, 32'h1);
        check("R8 rtc_irq from compare", {31'd0, rtc_irq}, 32'h1);
        ticks(4'b0001, 1);
        wr(2'd1, 32'h1); rd(2'd1, v); check("R11 compare flag cleared", v, 32'h0);
        ticks(4'b0001, 1); rd(2'd1, v); check("R6 no re-set while match persists", v, 32'h0);
        ticks(4'b0001, 10); rd(2'd1, v); check("R6 no flag past window", v, 32'h0);
        wr(2'd0, 32'h0);
        wr(2'd0, mk(1, 1, 0, 0, 12'd0, 0, 0, 2'd0, 0, 0, 10'd0));
        ticks(4'b0001, 2); rd(2'd1, v); check("R6 zero compare ignored", v, 32'h0);

        // R9: freeze
        wr(2'd0, 32'h0);
        wr(2'd0, mk(1, 0, 1, 0, 12'd0, 0, 0, 2'd0, 0, 0, 10'd0));
        ticks(4'b0001, 5);
        dbg_mode = 1'b1;
        ticks(4'b0001, 10); rd(2'd2, v); check("R9 frozen in debug", v, 32'd5);
        dbg_mode = 1'b0;
        ticks(4'b0001, 3); rd(2'd2, v); check("R9 resumes from held value", v, 32'd8);
        wr(2'd0, mk(1, 0, 0, 0, 12'd0, 0, 0, 2'd0, 0, 0, 10'd0));
        dbg_mode = 1'b1;
        ticks(4'b0001, 4); rd(2'd2, v); check("R9 debug ignored without freeze", v, 32'd12);
        dbg_mode = 1'b0;

        // R10 periodic length 4
        wr(2'd0, 32'h0);
        wr(2'd0, mk(1, 0, 0, 0, 12'd0, 1, 1, 2'd0, 0, 0, 10'd4));
        ticks(4'b0001, 3); rd(2'd1, v); check("R10 no event before length", v, 32'h0);
        ticks(4'b0001, 1); rd(2'd1, v); check("R10 event at length", v, 32'h2);
        check("R8 api_irq set", {31'd0, api_irq}, 32'h1);
        wr(2'd1, 32'h0); rd(2'd1, v); check("R11 write zero keeps flag", v, 32'h2);
        wr(2'd1, 32'h2); rd(2'd1, v); check("R11 periodic clear", v, 32'h0);
        ticks(4'b0001, 4); rd(2'd1, v); check("R10 second period", v, 32'h2);
        wr(2'd0, mk(1, 0, 0, 0, 12'd0, 1, 0, 2'd0, 0, 0, 10'd4));
        #1 check("R8 api_irq masked", {31'd0, api_irq}, 32'h0);
        // R3 disable clears flags
        wr(2'd0, 32'h0); rd(2'd1, v); check("R3 flags cleared by disable", v, 32'h0);
        wr(2'd0, mk(1, 0, 0, 0, 12'd0, 1, 0, 2'd0, 0, 0, 10'd0));
        ticks(4'b0001, 20); rd(2'd1, v); check("R10 zero length ignored", v, 32'h0);

        // R11 set and clear in the same cycle
        wr(2'd0, 32'h0);
        wr(2'd0, mk(1, 0, 0, 0, 12'd0, 1, 0, 2'd0, 0, 0, 10'd1));
        @(negedge clk);
        src_tick = 4'b0001; wr_en = 1'b1; addr = 2'd1; wr_data = 32'h2;
        @(negedge clk);
        src_tick = '0; wr_en = 1'b0;
        rd(2'd1, v); check("R11 set wins over clear", v, 32'h2);
        wr(2'd1, 32'h2); rd(2'd1, v); check("R11 clear alone", v, 32'h0);

        // R7 rollover with enable
        wr(2'd0, 32'h0);
        wr(2'd0, mk(1, 0, 0, 1, 12'd0, 0, 0, 2'd0, 0, 0, 10'd0));
        ticks(4'b0001, 16383); rd(2'd1, v); check("R7 no flag before wrap", v, 32'h0);
        ticks(4'b0001, 1);
        rd(2'd2, v); check("R7 count wrapped", v, 32'h0);
        rd(2'd1, v); check("R7 rollover flag", v, 32'h4);
        check("R7 wakeup", {31'd0, wakeup}, 32'h1);
        check("R8 rtc_irq masked", {31'd0, rtc_irq}, 32'h0);
        wr(2'd0, mk(1, 1, 0, 1, 12'd0, 0, 0, 2'd0, 0, 0, 10'd0));
        #1 check("R8 rtc_irq from rollover", {31'd0, rtc_irq}, 32'h1);
        // R7 rollover without enable
        wr(2'd0, 32'h0);
        wr(2'd0, mk(1, 0, 0, 0, 12'd0, 0, 0, 2'd0, 0, 0, 10'd0));
        ticks(4'b0001, 16384);
        rd(2'd1, v); check("R7 no flag without enable", v, 32'h0);
        check("R7 no wakeup without enable", {31'd0, wakeup}, 32'h0);

        // R2 system reset keeps control, power-on clears it
        wr(2'd0, mk(1, 0, 0, 0, 12'd7, 0, 0, 2'd1, 0, 0, 10'd9));
        ticks(4'b0010, 3);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(2'd0, v); check("R2 ctrl kept by system reset", v, mk(1, 0, 0, 0, 12'd7, 0, 0, 2'd1, 0, 0, 10'd9));
        rd(2'd2, v); check("R2 count cleared by system reset", v, 32'h0);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        rd(2'd0, v); check("R2 ctrl cleared by power-on", v, 32'h0);

        summary();
        $finish;
    end

endmodule